// File: doc/BRIEF.md
# Microcontroller Core Special-Register Bank

This block keeps the core special-function registers of an 8052-style controller in one place: the accumulator, the B scratch register, an 11-bit stack pointer split over a low byte and a three-bit high part, a 24-bit data pointer made of three byte lanes, the status word and the power-control register. The instruction decoder reaches them through a byte-wide read/write port with an 8-bit direct address. A second, single-bit port reaches the registers whose address ends in three zero bits. The datapath sends one-cycle strobes for stack push, stack pop and data-pointer increment, and the ALU sends carry, half-carry and overflow results to the status word.

The block feeds the rest of the core with the stack address, the data-pointer address, the selected register bank and the accumulator parity. It also drives one-cycle idle and power-down requests. These come from a small power state machine with three states. `PWR_RUN` is normal operation. A PCON write with the power-down bit set takes the transition T_SLEEP_DOWN into `PWR_DOWN`. A PCON write with only the idle bit set takes T_SLEEP_IDLE into `PWR_IDLE`. From either sleep state, the `wake` input takes T_WAKE back to `PWR_RUN` and clears both sleep bits.

Top module: `sfr_core_bank`

## Requirements
- R1: After reset, SP (address 81h) reads 07h, SPH (B7h) reads 00h, and `stack_addr` is 007h. ACC (E0h), B (F0h), DPL (82h), DPH (83h), DPP (84h), PSW (D0h) and PCON (87h) all read 00h. `dptr_addr`, `bank_sel`, `parity`, `idle_req` and `pd_req` are all zero.
- R2: A `push_stb` cycle without `pop_stb` adds one to the 11-bit stack pointer, modulo 2048. A carry out of the low byte goes into the high part. The new value shows on `stack_addr` from the next cycle on, so the first push after reset addresses 008h.
- R3: A `pop_stb` cycle without `push_stb` subtracts one, modulo 2048, with a borrow from the high part (000h becomes 7FFh). If both strobes are high in the same cycle, the pointer does not change.
- R4: SP at 81h holds stack-pointer bits 7:0. SPH at B7h holds bits 10:8 in its bits 2:0. Bits 7:3 of SPH read as zero whatever was written.
- R5: DPL (82h), DPH (83h) and DPP (84h) are written one at a time; a write to one lane leaves the other two lanes unchanged. `dptr_addr` is {DPP,DPH,DPL}. `dptr_inc_stb` adds one to this value, carrying DPL into DPH into DPP, and FFFFFFh wraps to 000000h.
- R6: In PSW, bit 7 is carry, bit 6 is half carry, bit 5 is F0, bits 4:3 are the bank select, bit 2 is overflow, bit 1 is F1 and bit 0 is parity. `bank_sel` equals bits 4:3. When `alu_flag_we` is high, carry, half carry and overflow take `alu_cy`, `alu_ac` and `alu_ov`, and the other bits stay as they are.
- R7: Any bit address with bit 7 set selects register {addr[7:3],000b}, bit addr[2:0]. Only ACC, B and PSW respond to it. `bit_rdata` returns the selected bit, and a bit write changes only that bit. Bit writes to any other bit address, including those in the 80h–87h group and those below 80h, change nothing, and those bits read as 0.
- R8: `parity` is the XOR of the accumulator bits. PSW bit 0 always reads as this value, and writes to PSW bit 0, by byte or by bit, are ignored.
- R9: When a byte write hits a register in the same cycle as a strobe, an ALU flag update or a bit write to that register, the byte write wins. For the stack this applies to both SP and SPH, and for the data pointer to any of its three lanes. The other update is dropped.
- R10: PCON at 87h stores all eight bits. A PCON write made in `PWR_RUN` with bit 1 set gives `pd_req` high for exactly the next cycle. A write with only bit 0 set gives `idle_req` the same way. The two requests are never high together.
- R11: In `PWR_IDLE` or `PWR_DOWN`, `wake` returns the block to `PWR_RUN` and clears PCON bits 1:0; bits 7:2 keep their values.
- R12: ACC and B read back what was written. Any direct address that is not mapped reads 00h.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| sfr_addr | input | 8 | Direct address for byte read and write |
| sfr_we | input | 1 | Byte write enable |
| sfr_wdata | input | 8 | Byte write data |
| sfr_rdata | output | 8 | Byte read data (combinational) |
| bit_addr | input | 8 | Bit address |
| bit_we | input | 1 | Bit write enable |
| bit_wdata | input | 1 | Bit write value |
| bit_rdata | output | 1 | Bit read value (combinational) |
| push_stb | input | 1 | Stack pre-increment strobe |
| pop_stb | input | 1 | Stack post-decrement strobe |
| dptr_inc_stb | input | 1 | Data-pointer increment strobe |
| alu_flag_we | input | 1 | ALU flag update enable |
| alu_cy | input | 1 | New carry flag |
| alu_ac | input | 1 | New half-carry flag |
| alu_ov | input | 1 | New overflow flag |
| wake | input | 1 | Wake from idle or power-down |
| stack_addr | output | 11 | Current stack pointer |
| dptr_addr | output | 24 | Current data pointer |
| bank_sel | output | 2 | Register bank select |
| parity | output | 1 | Accumulator parity |
| idle_req | output | 1 | One-cycle idle request |
| pd_req | output | 1 | One-cycle power-down request |

## Verification
The bench drives the stack pointer across the 0FFh/100h boundary and the 7FFh/000h wrap in both directions. A stack pointer that dropped the carry into SPH would fold back to 000h at the byte boundary, and one that did not wrap would address outside the 2 KB space. It increments the data pointer through the 00FFFFh and FFFFFFh boundaries, where a missing carry into the page byte would fail to reach 010000h. It sweeps every accumulator value for parity, every bit of every bit-addressable register, and every combination of ALU flags. A wrong bit decode would disturb a neighbouring bit or register, and a wrong parity would give the opposite value. It also makes byte writes collide with strobes and flag updates, and checks the power requests for both sleep modes. If the byte write did not win, a collision would leave an incremented or flag-modified value; a faulty request would last two cycles, or idle and power-down would be requested together.

// File: rtl/sfr_core_pkg.sv
package sfr_core_pkg;

    typedef logic [7:0] sfr_addr_t;

    localparam sfr_addr_t ADDR_SP   = 8'h81;
    localparam sfr_addr_t ADDR_DPL  = 8'h82;
    localparam sfr_addr_t ADDR_DPH  = 8'h83;
    localparam sfr_addr_t ADDR_DPP  = 8'h84;
    localparam sfr_addr_t ADDR_PCON = 8'h87;
    localparam sfr_addr_t ADDR_SPH  = 8'hB7;
    localparam sfr_addr_t ADDR_PSW  = 8'hD0;
    localparam sfr_addr_t ADDR_ACC  = 8'hE0;
    localparam sfr_addr_t ADDR_B    = 8'hF0;

    // status word bit positions
    localparam int unsigned PSW_CY = 7;
    localparam int unsigned PSW_AC = 6;
    localparam int unsigned PSW_OV = 2;

    // power-control bit positions
    localparam int unsigned PCON_PD  = 1;
    localparam int unsigned PCON_IDL = 0;

    typedef enum logic [1:0] {
        PWR_RUN  = 2'd0,
        PWR_IDLE = 2'd1,
        PWR_DOWN = 2'd2
    } pwr_state_e;

endpackage

// File: rtl/sfr_stack_ptr.sv
module sfr_stack_ptr #(
    parameter int unsigned SP_W      = 11,
    parameter int unsigned LO_W      = 8,
    parameter int unsigned RESET_VAL = 7
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            wr_lo,
    input  logic            wr_hi,
    input  logic [LO_W-1:0] wdata,
    input  logic            push,
    input  logic            pop,
    output logic [SP_W-1:0] sp_o
);
    localparam int unsigned HI_W = SP_W - LO_W;

    logic [SP_W-1:0] sp_q;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sp_q <= SP_W'(RESET_VAL);
        end else if (wr_lo || wr_hi) begin
            // direct write beats any strobe in the same cycle
            if (wr_lo) sp_q[LO_W-1:0]    <= wdata;
            if (wr_hi) sp_q[SP_W-1:LO_W] <= wdata[HI_W-1:0];
        end else if (push && !pop) begin
            sp_q <= sp_q + SP_W'(1);
        end else if (pop && !push) begin
            sp_q <= sp_q - SP_W'(1);
        end
    end

    assign sp_o = sp_q;

endmodule

// File: rtl/sfr_data_ptr.sv
module sfr_data_ptr #(
    parameter int unsigned NBYTES = 3
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic [NBYTES-1:0]     wr_lane,
    input  logic [7:0]            wdata,
    input  logic                  inc,
    output logic [8*NBYTES-1:0]   dptr_o
);
    localparam int unsigned DP_W = 8 * NBYTES;

    logic [7:0]      lane_q [NBYTES];
    logic [DP_W-1:0] dp_next;

    for (genvar g = 0; g < NBYTES; g++) begin : g_pack
        assign dptr_o[8*g +: 8] = lane_q[g];
    end

    assign dp_next = dptr_o + DP_W'(1);

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < NBYTES; i++) lane_q[i] <= 8'h00;
        end else if (|wr_lane) begin
            for (int i = 0; i < NBYTES; i++) begin
                if (wr_lane[i]) lane_q[i] <= wdata;
            end
        end else if (inc) begin
            for (int i = 0; i < NBYTES; i++) lane_q[i] <= dp_next[8*i +: 8];
        end
    end

endmodule

// File: rtl/sfr_power_ctl.sv
module sfr_power_ctl
    import sfr_core_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       wr,
    input  logic [7:0] wdata,
    input  logic       wake,
    output logic [7:0] pcon_o,
    output logic       idle_req,
    output logic       pd_req
);
    pwr_state_e state_q, state_d;
    logic [7:0] pcon_q;
    logic       go_down, go_idle;

    assign go_down = wr && wdata[PCON_PD];
    assign go_idle = wr && wdata[PCON_IDL] && !wdata[PCON_PD];

    // next-state logic
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            PWR_RUN: begin
                if (go_down)      state_d = PWR_DOWN;   // T_SLEEP_DOWN
                else if (go_idle) state_d = PWR_IDLE;   // T_SLEEP_IDLE
            end
            PWR_IDLE,
            PWR_DOWN: begin
                if (wake && !wr)  state_d = PWR_RUN;    // T_WAKE
            end
            default:              state_d = PWR_RUN;
        endcase
    end

    // state register
    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= PWR_RUN;
        else        state_q <= state_d;
    end

    // register contents
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pcon_q <= 8'h00;
        end else if (wr) begin
            pcon_q <= wdata;
        end else if (wake && state_q != PWR_RUN) begin
            pcon_q[PCON_PD]  <= 1'b0;
            pcon_q[PCON_IDL] <= 1'b0;
        end
    end

    // registered request pulses
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pd_req   <= 1'b0;
            idle_req <= 1'b0;
        end else begin
            pd_req   <= (state_q == PWR_RUN) && go_down;
            idle_req <= (state_q == PWR_RUN) && go_idle;
        end
    end

    assign pcon_o = pcon_q;

endmodule

// File: rtl/sfr_core_bank.sv
module sfr_core_bank
    import sfr_core_pkg::*;
#(
    parameter int unsigned SP_W     = 11,
    parameter int unsigned DP_BYTES = 3,
    parameter int unsigned SP_RESET = 7
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic [7:0]            sfr_addr,
    input  logic                  sfr_we,
    input  logic [7:0]            sfr_wdata,
    output logic [7:0]            sfr_rdata,
    input  logic [7:0]            bit_addr,
    input  logic                  bit_we,
    input  logic                  bit_wdata,
    output logic                  bit_rdata,
    input  logic                  push_stb,
    input  logic                  pop_stb,
    input  logic                  dptr_inc_stb,
    input  logic                  alu_flag_we,
    input  logic                  alu_cy,
    input  logic                  alu_ac,
    input  logic                  alu_ov,
    input  logic                  wake,
    output logic [SP_W-1:0]       stack_addr,
    output logic [8*DP_BYTES-1:0] dptr_addr,
    output logic [1:0]            bank_sel,
    output logic                  parity,
    output logic                  idle_req,
    output logic                  pd_req
);
    localparam int unsigned SP_HI_W = SP_W - 8;

    logic [7:0] acc_q, b_q;
    logic [7:1] psw_q;
    logic [7:0] pcon;
    logic [7:0] psw_rd;

    // bit-port decode
    logic       bit_hit;
    sfr_addr_t  bit_base;
    logic [2:0] bit_idx;

    assign bit_hit  = bit_addr[7];
    assign bit_base = {bit_addr[7:3], 3'b000};
    assign bit_idx  = bit_addr[2:0];

    logic wr_acc, wr_b, wr_psw, wr_pcon, wr_sp, wr_sph;
    logic bw_acc, bw_b, bw_psw;

    assign wr_acc  = sfr_we && sfr_addr == ADDR_ACC;
    assign wr_b    = sfr_we && sfr_addr == ADDR_B;
    assign wr_psw  = sfr_we && sfr_addr == ADDR_PSW;
    assign wr_pcon = sfr_we && sfr_addr == ADDR_PCON;
    assign wr_sp   = sfr_we && sfr_addr == ADDR_SP;
    assign wr_sph  = sfr_we && sfr_addr == ADDR_SPH;

    assign bw_acc  = bit_we && bit_hit && bit_base == ADDR_ACC;
    assign bw_b    = bit_we && bit_hit && bit_base == ADDR_B;
    assign bw_psw  = bit_we && bit_hit && bit_base == ADDR_PSW && bit_idx != 3'd0;

    // data-pointer lane write strobes, lane 0 at ADDR_DPL
    logic [DP_BYTES-1:0] wr_dp;
    for (genvar g = 0; g < DP_BYTES; g++) begin : g_dpwr
        assign wr_dp[g] = sfr_we && sfr_addr == ADDR_DPL + 8'(g);
    end

    // accumulator and B
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            acc_q <= 8'h00;
            b_q   <= 8'h00;
        end else begin
            if (wr_acc)      acc_q          <= sfr_wdata;
            else if (bw_acc) acc_q[bit_idx] <= bit_wdata;
            if (wr_b)        b_q            <= sfr_wdata;
            else if (bw_b)   b_q[bit_idx]   <= bit_wdata;
        end
    end

    // status word; bit 0 is not stored
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            psw_q <= 7'h00;
        end else if (wr_psw) begin
            psw_q <= sfr_wdata[7:1];
        end else if (bw_psw) begin
            psw_q[bit_idx] <= bit_wdata;
        end else if (alu_flag_we) begin
            psw_q[PSW_CY] <= alu_cy;
            psw_q[PSW_AC] <= alu_ac;
            psw_q[PSW_OV] <= alu_ov;
        end
    end

    assign parity   = ^acc_q;
    assign psw_rd   = {psw_q, parity};
    assign bank_sel = psw_q[4:3];

    sfr_stack_ptr #(
        .SP_W      (SP_W),
        .LO_W      (8),
        .RESET_VAL (SP_RESET)
    ) u_sp (
        .clk   (clk),
        .rst_n (rst_n),
        .wr_lo (wr_sp),
        .wr_hi (wr_sph),
        .wdata (sfr_wdata),
        .push  (push_stb),
        .pop   (pop_stb),
        .sp_o  (stack_addr)
    );

    sfr_data_ptr #(
        .NBYTES (DP_BYTES)
    ) u_dp (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_lane (wr_dp),
        .wdata   (sfr_wdata),
        .inc     (dptr_inc_stb),
        .dptr_o  (dptr_addr)
    );

    sfr_power_ctl u_pwr (
        .clk      (clk),
        .rst_n    (rst_n),
        .wr       (wr_pcon),
        .wdata    (sfr_wdata),
        .wake     (wake),
        .pcon_o   (pcon),
        .idle_req (idle_req),
        .pd_req   (pd_req)
    );

    // byte read mux
    always_comb begin
        sfr_rdata = 8'h00;
        for (int i = 0; i < DP_BYTES; i++) begin
            if (sfr_addr == ADDR_DPL + 8'(i)) sfr_rdata = dptr_addr[8*i +: 8];
        end
        case (sfr_addr)
            ADDR_ACC:  sfr_rdata = acc_q;
            ADDR_B:    sfr_rdata = b_q;
            ADDR_PSW:  sfr_rdata = psw_rd;
            ADDR_PCON: sfr_rdata = pcon;
            ADDR_SP:   sfr_rdata = stack_addr[7:0];
            ADDR_SPH:  sfr_rdata = {{(8-SP_HI_W){1'b0}}, stack_addr[SP_W-1:8]};
            default:   ;
        endcase
    end

    // bit read mux
    always_comb begin
        bit_rdata = 1'b0;
        if (bit_hit) begin
            case (bit_base)
                ADDR_ACC: bit_rdata = acc_q[bit_idx];
                ADDR_B:   bit_rdata = b_q[bit_idx];
                ADDR_PSW: bit_rdata = psw_rd[bit_idx];
                default:  bit_rdata = 1'b0;
            endcase
        end
    end

endmodule

// File: rtl/sfr_core_bank_chk.sv
module sfr_core_bank_chk (
    input logic        clk,
    input logic        rst_n,
    input logic [7:0]  sfr_addr,
    input logic        sfr_we,
    input logic [7:0]  sfr_rdata,
    input logic        push_stb,
    input logic        pop_stb,
    input logic        dptr_inc_stb,
    input logic [10:0] stack_addr,
    input logic [23:0] dptr_addr,
    input logic [1:0]  bank_sel,
    input logic        parity,
    input logic        idle_req,
    input logic        pd_req
);
    logic armed;
    logic sp_wr, dp_wr;

    always_ff @(posedge clk) begin
        if (!rst_n) armed <= 1'b0;
        else        armed <= 1'b1;
    end

    assign sp_wr = sfr_we && (sfr_addr == 8'h81 || sfr_addr == 8'hB7);
    assign dp_wr = sfr_we && (sfr_addr >= 8'h82 && sfr_addr <= 8'h84);

    AST_PUSH_PRE_INC: assert property (@(posedge clk) disable iff (!rst_n)
        (armed && push_stb && !pop_stb && !sp_wr) |=> stack_addr == $past(stack_addr) + 11'd1); // R2
    AST_POP_POST_DEC: assert property (@(posedge clk) disable iff (!rst_n)
        (armed && pop_stb && !push_stb && !sp_wr) |=> stack_addr == $past(stack_addr) - 11'd1); // R3
    AST_SPH_UPPER_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        (sfr_addr == 8'hB7) |-> sfr_rdata[7:3] == 5'd0); // R4
    AST_DPTR_CARRY_INC: assert property (@(posedge clk) disable iff (!rst_n)
        (armed && dptr_inc_stb && !dp_wr) |=> dptr_addr == $past(dptr_addr) + 24'd1); // R5
    AST_BANK_MATCHES_PSW: assert property (@(posedge clk) disable iff (!rst_n)
        (sfr_addr == 8'hD0) |-> bank_sel == sfr_rdata[4:3]); // R6
    AST_PARITY_OF_ACC: assert property (@(posedge clk) disable iff (!rst_n)
        (sfr_addr == 8'hE0) |-> parity == ^sfr_rdata); // R8
    AST_PSW_PARITY_BIT: assert property (@(posedge clk) disable iff (!rst_n)
        (sfr_addr == 8'hD0) |-> sfr_rdata[0] == parity); // R8
    AST_REQ_EXCLUSIVE: assert property (@(posedge clk) disable iff (!rst_n)
        !(idle_req && pd_req)); // R10
    AST_IDLE_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
        idle_req |=> !idle_req); // R10
    AST_PD_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
        pd_req |=> !pd_req); // R10

endmodule

bind sfr_core_bank sfr_core_bank_chk chk_i (.*);

// File: tb/sfr_core_bank_tb_top.sv
module sfr_core_bank_tb_top;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [7:0]  sfr_addr = 8'h00;
    logic        sfr_we = 1'b0;
    logic [7:0]  sfr_wdata = 8'h00;
    logic [7:0]  sfr_rdata;
    logic [7:0]  bit_addr = 8'h00;
    logic        bit_we = 1'b0;
    logic        bit_wdata = 1'b0;
    logic        bit_rdata;
    logic        push_stb = 1'b0;
    logic        pop_stb = 1'b0;
    logic        dptr_inc_stb = 1'b0;
    logic        alu_flag_we = 1'b0;
    logic        alu_cy = 1'b0;
    logic        alu_ac = 1'b0;
    logic        alu_ov = 1'b0;
    logic        wake = 1'b0;
    logic [10:0] stack_addr;
    logic [23:0] dptr_addr;
    logic [1:0]  bank_sel;
    logic        parity;
    logic        idle_req;
    logic        pd_req;

    int n_chk = 0;
    int n_err = 0;
    bit done  = 1'b0;

    always #4 clk = ~clk;

    sfr_core_bank dut_i (.*);

    task automatic chk(input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_err++;
            $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
        end
    endtask

    task automatic tick();
        @(posedge clk);
        @(negedge clk);
    endtask

    task automatic wr(input logic [7:0] a, input logic [7:0] d);
        sfr_addr = a; sfr_wdata = d; sfr_we = 1'b1;
        tick();
        sfr_we = 1'b0;
    endtask

    task automatic rd(input logic [7:0] a, output logic [7:0] d);
        sfr_addr = a;
        #1;
        d = sfr_rdata;
    endtask

    task automatic bwr(input logic [7:0] a, input logic v);
        bit_addr = a; bit_wdata = v; bit_we = 1'b1;
        tick();
        bit_we = 1'b0;
    endtask

    function automatic logic par8(input int v);
        int ones = 0;
        for (int k = 0; k < 8; k++) ones += (v >> k) & 1;
        return logic'(ones % 2);
    endfunction

    initial begin
        #(8 * 200000);
        if (!done) begin
            n_chk++;
            n_err++;
            $display("FAIL watchdog: actual running expected finished");
            $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
            $finish;
        end
    end

    initial begin
        logic [7:0] r;
        int exp_sp;
        int exp_dp;
        int psw_base;

        repeat (3) tick();
        rst_n = 1'b1;
        tick();

        // R1 reset state
        rd(8'h81, r); chk("R1", "SP", r, 8'h07);
        rd(8'hB7, r); chk("R1", "SPH", r, 8'h00);
        chk("R1", "stack_addr", stack_addr, 11'h007);
        foreach (dut_i.sfr_rdata[i]) ; // no-op
        rd(8'hE0, r); chk("R1", "ACC", r, 0);
        rd(8'hF0, r); chk("R1", "B", r, 0);
        rd(8'h82, r); chk("R1", "DPL", r, 0);
        rd(8'h83, r); chk("R1", "DPH", r, 0);
        rd(8'h84, r); chk("R1", "DPP", r, 0);
        rd(8'hD0, r); chk("R1", "PSW", r, 0);
        rd(8'h87, r); chk("R1", "PCON", r, 0);
        chk("R1", "dptr_addr", dptr_addr, 0);
        chk("R1", "bank/parity/req", {bank_sel, parity, idle_req, pd_req}, 0);

        // R2 first push lands at 008h
        push_stb = 1'b1; tick(); push_stb = 1'b0;
        chk("R2", "first push", stack_addr, 11'h008);

        // R12 / R8 exhaustive accumulator sweep
        for (int v = 0; v < 256; v++) begin
            wr(8'hE0, 8'(v));
            rd(8'hE0, r); chk("R12", "ACC readback", r, v);
            chk("R8", "parity", parity, par8(v));
            rd(8'hD0, r); chk("R8", "PSW bit0", r[0], par8(v));
        end
        wr(8'hF0, 8'hA5); rd(8'hF0, r); chk("R12", "B readback", r, 8'hA5);
        rd(8'h80, r); chk("R12", "unmapped 80", r, 0);
        rd(8'h85, r); chk("R12", "unmapped 85", r, 0);
        rd(8'hA0, r); chk("R12", "unmapped A0", r, 0);
        // R8 writes to parity bit ignored: ACC=00 so parity 0
        wr(8'hE0, 8'h00);
        wr(8'hD0, 8'h01); rd(8'hD0, r); chk("R8", "PSW bit0 byte write", r, 8'h00);
        bwr(8'hD0, 1'b1); rd(8'hD0, r); chk("R8", "PSW bit0 bit write", r, 8'h00);

        // R4 SPH upper bits
        wr(8'hB7, 8'hFF); rd(8'hB7, r); chk("R4", "SPH mask", r, 8'h07);
        chk("R4", "stack hi", stack_addr[10:8], 3'h7);

        // R2 push sweep across 0FFh and 7FFh
        wr(8'hB7, 8'h00); wr(8'h81, 8'hF8); exp_sp = 'h0F8;
        for (int n = 0; n < 16; n++) begin
            push_stb = 1'b1; tick(); push_stb = 1'b0;
            exp_sp = (exp_sp + 1) % 2048;
            chk("R2", "push carry", stack_addr, exp_sp);
        end
        rd(8'hB7, r); chk("R2", "SPH after carry", r, 8'h01);
        wr(8'hB7, 8'h07); wr(8'h81, 8'hFD); exp_sp = 'h7FD;
        for (int n = 0; n < 5; n++) begin
            push_stb = 1'b1; tick(); push_stb = 1'b0;
            exp_sp = (exp_sp + 1) % 2048;
            chk("R2", "push wrap", stack_addr, exp_sp);
        end

        // R3 pop sweep across 000h and 100h
        for (int n = 0; n < 6; n++) begin
            pop_stb = 1'b1; tick(); pop_stb = 1'b0;
            exp_sp = (exp_sp + 2047) % 2048;
            chk("R3", "pop wrap", stack_addr, exp_sp);
        end
        wr(8'hB7, 8'h01); wr(8'h81, 8'h02); exp_sp = 'h102;
        for (int n = 0; n < 5; n++) begin
            pop_stb = 1'b1; tick(); pop_stb = 1'b0;
            exp_sp = (exp_sp + 2047) % 2048;
            chk("R3", "pop borrow", stack_addr, exp_sp);
        end
        push_stb = 1'b1; pop_stb = 1'b1; tick(); push_stb = 1'b0; pop_stb = 1'b0;
        chk("R3", "push+pop hold", stack_addr, exp_sp);

        // R9 SP write beats push
        sfr_addr = 8'h81; sfr_wdata = 8'h40; sfr_we = 1'b1; push_stb = 1'b1;
        tick(); sfr_we = 1'b0; push_stb = 1'b0;
        chk("R9", "SP write vs push", stack_addr, {3'h0, 8'h40});

        // R5 data pointer lanes and carries
        wr(8'h84, 8'h00); wr(8'h83, 8'hFF); wr(8'h82, 8'hFD); exp_dp = 'h00FFFD;
        for (int n = 0; n < 5; n++) begin
            dptr_inc_stb = 1'b1; tick(); dptr_inc_stb = 1'b0;
            exp_dp = (exp_dp + 1) % (1 << 24);
            chk("R5", "dptr carry", dptr_addr, exp_dp);
        end
        rd(8'h84, r); chk("R5", "DPP after carry", r, 8'h01);
        wr(8'h84, 8'hFF); wr(8'h83, 8'hFF); wr(8'h82, 8'hFF);
        dptr_inc_stb = 1'b1; tick(); dptr_inc_stb = 1'b0;
        chk("R5", "dptr wrap", dptr_addr, 24'h000000);
        wr(8'h83, 8'h5A); chk("R5", "DPH only", dptr_addr, 24'h005A00);
        wr(8'h84, 8'h3C); chk("R5", "DPP only", dptr_addr, 24'h3C5A00);
        // R9 lane write beats increment
        sfr_addr = 8'h82; sfr_wdata = 8'h11; sfr_we = 1'b1; dptr_inc_stb = 1'b1;
        tick(); sfr_we = 1'b0; dptr_inc_stb = 1'b0;
        chk("R9", "DPL write vs inc", dptr_addr, 24'h3C5A11);

        // R6 bank select from PSW bits 4:3
        for (int bk = 0; bk < 4; bk++) begin
            wr(8'hD0, 8'(bk << 3));
            chk("R6", "bank_sel", bank_sel, bk);
        end
        // R6 ALU flag sweep (ACC=00 so parity 0)
        psw_base = 'h3A;
        for (int f = 0; f < 8; f++) begin
            wr(8'hD0, 8'(psw_base));
            alu_cy = f[2]; alu_ac = f[1]; alu_ov = f[0]; alu_flag_we = 1'b1;
            tick(); alu_flag_we = 1'b0;
            rd(8'hD0, r);
            chk("R6", "alu flags", r,
                (psw_base & 'h3B & ~'h04) | (f[2] << 7) | (f[1] << 6) | (f[0] << 2));
        end
        // R9 PSW write beats flag update
        sfr_addr = 8'hD0; sfr_wdata = 8'h20; sfr_we = 1'b1;
        alu_cy = 1'b1; alu_ac = 1'b1; alu_ov = 1'b1; alu_flag_we = 1'b1;
        tick(); sfr_we = 1'b0; alu_flag_we = 1'b0;
        rd(8'hD0, r); chk("R9", "PSW write vs flags", r, 8'h20);

        // R7 bit access on every bit of ACC, B, PSW
        for (int t = 0; t < 3; t++) begin
            logic [7:0] base;
            base = (t == 0) ? 8'hE0 : (t == 1) ? 8'hF0 : 8'hD0;
            for (int k = 0; k < 8; k++) begin
                int expv;
                wr(8'hE0, 8'h00); wr(base, 8'h00);
                bwr(base | 8'(k), 1'b1);
                if (t == 2 && k == 0) expv = 0;
                else if (t == 0) expv = 1 << k;
                else expv = 1 << k;
                rd(base, r); chk("R7", "bit set", r, expv);
                bit_addr = base | 8'(k); #1;
                chk("R7", "bit read", bit_rdata, expv != 0);
                bwr(base | 8'(k), 1'b0);
                rd(base, r); chk("R7", "bit clear", r, 0);
            end
        end
        wr(8'hE0, 8'h5A);
        wr(8'h81, 8'h33);
        wr(8'h87, 8'h40);
        for (int a = 'h80; a < 'h88; a++) bwr(8'(a), 1'b1);
        bwr(8'h05, 1'b1);
        bwr(8'h7F, 1'b0);
        rd(8'h81, r); chk("R7", "SP untouched", r, 8'h33);
        rd(8'h87, r); chk("R7", "PCON untouched", r, 8'h40);
        rd(8'hE0, r); chk("R7", "ACC untouched", r, 8'h5A);
        chk("R7", "idle after ignored bits", idle_req, 1'b0);
        bit_addr = 8'h87; #1; chk("R7", "unmapped bit read", bit_rdata, 1'b0);
        // R9 byte write beats bit write
        sfr_addr = 8'hE0; sfr_wdata = 8'h00; sfr_we = 1'b1;
        bit_addr = 8'hE3; bit_wdata = 1'b1; bit_we = 1'b1;
        tick(); sfr_we = 1'b0; bit_we = 1'b0;
        rd(8'hE0, r); chk("R9", "byte vs bit write", r, 8'h00);

        // R10 idle request
        wr(8'h87, 8'h01);
        chk("R10", "idle pulse", {idle_req, pd_req}, 2'b10);
        tick();
        chk("R10", "idle single", {idle_req, pd_req}, 2'b00);
        rd(8'h87, r); chk("R10", "PCON idle bit", r, 8'h01);
        // R11 wake
        wake = 1'b1; tick(); wake = 1'b0;
        rd(8'h87, r); chk("R11", "wake clears IDL", r, 8'h00);
        // R10 power-down wins over idle
        wr(8'h87, 8'h03);
        chk("R10", "pd pulse", {idle_req, pd_req}, 2'b01);
        tick();
        chk("R10", "pd single", {idle_req, pd_req}, 2'b00);
        wake = 1'b1; tick(); wake = 1'b0;
        // R10 other bits give no request, stored verbatim
        wr(8'h87, 8'h9C);
        chk("R10", "no request", {idle_req, pd_req}, 2'b00);
        rd(8'h87, r); chk("R10", "PCON store", r, 8'h9C);
        // R11 wake keeps upper bits
        wr(8'h87, 8'hF2);
        chk("R10", "pd pulse 2", pd_req, 1'b1);
        tick();
        wake = 1'b1; tick(); wake = 1'b0;
        rd(8'h87, r); chk("R11", "wake keeps 7:2", r, 8'hF0);
        wr(8'h87, 8'h01);
        chk("R11", "idle again after wake", idle_req, 1'b1);
        tick();
        wake = 1'b1; tick(); wake = 1'b0;

        done = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
        $finish;
    end

endmodule